// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter for a Dual-Channel Serial Controller

This block arbitrates between eight interrupt sources of a two-channel serial controller: receive, transmit, external-status and error for each channel. Each source holds a pending flag and an in-service flag. The block drives one interrupt request line toward the processor. When the processor acknowledges, the block hands back an 8-bit vector. It forms that vector from a programmable base by adding twice the index of the winning source.

Two numberings exist. Each source has a fixed index that sets its vector offset. It also has a fixed rank that sets its priority, and the rank order is not the index order. A source that is in service blocks every source ranked below it from raising the request line. It does this until a return-from-interrupt strobe retires it. A per-channel reset wipes that channel's four sources.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: Source indices, and bit positions in `set_req`/`clr_req`: channel B transmit 0, status 1, receive 2, error 3; channel A transmit 4, status 5, receive 6, error 7.
- R2: Priority from highest to lowest: A receive (6), A transmit (4), A status (5), A error (7), B receive (2), B transmit (0), B status (1), B error (3).
- R3: `irq` and `int_pending` are both the OR of the pending flags, taken in priority order and stopping at the first in-service source. A source ranked below an in-service source cannot raise them.
- R4: When `iack` is high, the highest-priority pending source is chosen regardless of in-service state. That source's pending flag clears and its in-service flag sets. In the next cycle, `vector_valid` is high for one cycle and `vector` equals base + 2*index, modulo 256. `vector` holds its value between acknowledges.
- R5: When `iack` finds no source pending, `vector` equals the base unchanged and no flag changes.
- R6: `reti` clears the in-service flag of the highest-priority in-service source, and no other. `in_service` is the OR of all in-service flags.
- R7: `chan_reset[1]` clears both flags of sources 4 to 7. `chan_reset[0]` clears both flags of sources 0 to 3. Sources of the other channel are untouched.
- R8: In the same cycle, a set request wins over a clear request for the same source, and a channel reset wins over both.
- R9: `iack` and `reti` in the same cycle both take effect. If they touch the same source, the acknowledge wins. A base write in the same cycle as `iack` takes effect only for later acknowledges.
- R10: After synchronous reset all flags are clear, and the base, `vector`, `vector_valid`, `irq` and `in_service` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 8 | Per-source pending set, bit = source index |
| clr_req | input | 8 | Per-source pending clear |
| chan_reset | input | 2 | Bit 1 resets channel A sources, bit 0 channel B |
| base_we | input | 1 | Load vector base |
| base_din | input | 8 | New vector base |
| iack | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Masked interrupt request |
| int_pending | output | 1 | Status copy of the masked request |
| in_service | output | 1 | Any source in service |
| vector | output | 8 | Vector from last acknowledge |
| vector_valid | output | 1 | High the cycle after an acknowledge |

## Verification
Two pairs of events can land in one cycle. The first pair is acknowledge and return-from-interrupt. The bench forces these together in a directed case, where a newly acknowledged source sits above the one being retired. Random stimulus also makes them coincide often. The second pair is a set request and an acknowledge or clear of the same source. For both pairs, a bench model applies the precedence stated in R8 and R9 to the previous flags. It then compares request, in-service and vector one cycle later.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_CH  = 2;
    localparam int CH_SRC  = 4;
    localparam int NUM_SRC = NUM_CH * CH_SRC;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int KIND_W  = $clog2(CH_SRC);
    localparam int VEC_W   = 8;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [VEC_W-1:0]   vec_t;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] idx;
    } pick_t;

    // Rank 0 is the highest priority; channel A (upper index half) ranks first.
    function automatic logic [SRC_W-1:0] rank_to_src(input int rank);
        logic [KIND_W-1:0] kind;
        int                ch;
        ch = (NUM_CH - 1) - (rank / CH_SRC);
        case (rank % CH_SRC)
            0:       kind = KIND_W'(2);  // receive
            1:       kind = KIND_W'(0);  // transmit
            2:       kind = KIND_W'(1);  // status
            default: kind = KIND_W'(3);  // error
        endcase
        return SRC_W'(ch * CH_SRC) + SRC_W'(kind);
    endfunction

    function automatic vec_t vector_of(input vec_t base, input pick_t p);
        return p.hit ? base + vec_t'({p.idx, 1'b0}) : base;
    endfunction
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  src_vec_t ins,
    output logic     req,
    output pick_t    ack_pick,
    output pick_t    reti_pick
);
    always_comb begin
        logic blocked;
        req       = 1'b0;
        blocked   = 1'b0;
        ack_pick  = '0;
        reti_pick = '0;
        for (int r = 0; r < NUM_SRC; r++) begin
            if (ins[rank_to_src(r)])
                blocked = 1'b1;
            if (!blocked && pend[rank_to_src(r)])
                req = 1'b1;
            if (!ack_pick.hit && pend[rank_to_src(r)]) begin
                ack_pick.hit = 1'b1;
                ack_pick.idx = rank_to_src(r);
            end
            if (!reti_pick.hit && ins[rank_to_src(r)]) begin
                reti_pick.hit = 1'b1;
                reti_pick.idx = rank_to_src(r);
            end
        end
    end

    // R3
    req_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (|pend));
    // R2
    ack_pick_pending_chk: assert property (@(posedge clk) disable iff (rst)
        ack_pick.hit |-> pend[ack_pick.idx]);
    // R6
    reti_pick_inserv_chk: assert property (@(posedge clk) disable iff (rst)
        reti_pick.hit |-> ins[reti_pick.idx]);
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  src_vec_t          set_req,
    input  src_vec_t          clr_req,
    input  logic [NUM_CH-1:0] chan_reset,
    input  src_vec_t          ack_hot,
    input  src_vec_t          reti_hot,
    output src_vec_t          pend,
    output src_vec_t          ins
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || chan_reset[s / CH_SRC]) begin
                pend[s] <= 1'b0;
                ins[s]  <= 1'b0;
            end else begin
                pend[s] <= (pend[s] & ~clr_req[s] & ~ack_hot[s]) | set_req[s];
                ins[s]  <= (ins[s] & ~reti_hot[s]) | ack_hot[s];
            end
        end
    end

    // R7
    chan_a_clear_chk: assert property (@(posedge clk) disable iff (rst)
        chan_reset[1] |=> (pend[NUM_SRC-1 -: CH_SRC] == '0) && (ins[NUM_SRC-1 -: CH_SRC] == '0));
    // R7
    chan_b_clear_chk: assert property (@(posedge clk) disable iff (rst)
        chan_reset[0] |=> (pend[CH_SRC-1:0] == '0) && (ins[CH_SRC-1:0] == '0));
    // R6
    reti_single_chk: assert property (@(posedge clk) disable iff (rst)
        ((|reti_hot) && !(|ack_hot) && !(|chan_reset)) |=>
            ($countones(ins) == $countones($past(ins)) - 1));
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_we,
    input  vec_t  base_din,
    input  logic  iack,
    input  pick_t ack_pick,
    output vec_t  vector,
    output logic  vector_valid
);
    vec_t base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q       <= '0;
            vector       <= '0;
            vector_valid <= 1'b0;
        end else begin
            vector_valid <= iack;
            if (iack)
                vector <= vector_of(base_q, ack_pick);
            if (base_we)
                base_q <= base_din;
        end
    end

    // R4
    valid_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        iack |=> vector_valid);
    // R4
    vector_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !iack |=> $stable(vector) && !vector_valid);
    // R5
    empty_ack_base_chk: assert property (@(posedge clk) disable iff (rst)
        (iack && !ack_pick.hit) |=> (vector == $past(base_q)));
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] set_req,
    input  logic [7:0] clr_req,
    input  logic [1:0] chan_reset,
    input  logic       base_we,
    input  logic [7:0] base_din,
    input  logic       iack,
    input  logic       reti,
    output logic       irq,
    output logic       int_pending,
    output logic       in_service,
    output logic [7:0] vector,
    output logic       vector_valid
);
    src_vec_t pend, ins, ack_hot, reti_hot;
    pick_t    ack_pick, reti_pick;
    logic     req;

    assign ack_hot  = (iack && ack_pick.hit)  ? (src_vec_t'(1) << ack_pick.idx)  : '0;
    assign reti_hot = (reti && reti_pick.hit) ? (src_vec_t'(1) << reti_pick.idx) : '0;

    irq_src_state i_state (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req),
        .chan_reset(chan_reset), .ack_hot(ack_hot), .reti_hot(reti_hot),
        .pend(pend), .ins(ins)
    );

    irq_prio_scan i_scan (
        .clk(clk), .rst(rst), .pend(pend), .ins(ins), .req(req),
        .ack_pick(ack_pick), .reti_pick(reti_pick)
    );

    irq_vec_out i_vec (
        .clk(clk), .rst(rst), .base_we(base_we), .base_din(base_din),
        .iack(iack), .ack_pick(ack_pick), .vector(vector),
        .vector_valid(vector_valid)
    );

    assign irq         = req;
    assign int_pending = req;
    assign in_service  = |ins;

    // R3
    masked_by_top_chk: assert property (@(posedge clk) disable iff (rst)
        ins[rank_to_src(0)] |-> !irq);
    // R9
    ack_sets_inserv_chk: assert property (@(posedge clk) disable iff (rst)
        (iack && ack_pick.hit && !(|chan_reset)) |=> in_service);
endmodule

// File: tb/test_irq_daisy_ctrl.sv
module test_irq_daisy_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] set_req, clr_req, base_din;
    logic [1:0] chan_reset;
    logic       base_we, iack, reti;
    logic       irq, int_pending, in_service, vector_valid;
    logic [7:0] vector;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_pend, m_ins, m_base, m_vec;
    logic       m_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_daisy_ctrl i_irq_daisy_ctrl (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req),
        .chan_reset(chan_reset), .base_we(base_we), .base_din(base_din),
        .iack(iack), .reti(reti), .irq(irq), .int_pending(int_pending),
        .in_service(in_service), .vector(vector), .vector_valid(vector_valid)
    );

    function automatic int rank_src(input int r);
        int kinds [4] = '{2, 0, 1, 3};
        return (1 - r / 4) * 4 + kinds[r % 4];
    endfunction

    function automatic logic exp_req(input logic [7:0] p, input logic [7:0] i);
        for (int r = 0; r < 8; r++) begin
            if (i[rank_src(r)]) return 1'b0;
            if (p[rank_src(r)]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int first_set(input logic [7:0] v);
        for (int r = 0; r < 8; r++)
            if (v[rank_src(r)]) return rank_src(r);
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] s, input logic [7:0] c, input logic [1:0] cr,
                        input logic a, input logic r, input logic w, input logic [7:0] d);
        int aw, rw;
        logic [7:0] ahot, rhot;
        set_req = s; clr_req = c; chan_reset = cr; iack = a; reti = r;
        base_we = w; base_din = d;
        aw = first_set(m_pend);
        rw = first_set(m_ins);
        ahot = (a && aw >= 0) ? 8'(1 << aw) : 8'h00;
        rhot = (r && rw >= 0) ? 8'(1 << rw) : 8'h00;
        m_valid = a;
        if (a) m_vec = (aw >= 0) ? m_base + 8'(2 * aw) : m_base;
        m_ins  = (m_ins & ~rhot) | ahot;
        m_pend = (m_pend & ~c & ~ahot) | s;
        if (cr[0]) begin m_pend[3:0] = '0; m_ins[3:0] = '0; end
        if (cr[1]) begin m_pend[7:4] = '0; m_ins[7:4] = '0; end
        if (w) m_base = d;
        @(posedge clk);
        @(negedge clk);
        set_req = '0; clr_req = '0; chan_reset = '0; iack = 0; reti = 0; base_we = 0;
        chk("R3 irq", irq, exp_req(m_pend, m_ins));
        chk("R3 int_pending", int_pending, exp_req(m_pend, m_ins));
        chk("R6 in_service", in_service, |m_ins);
        chk("R4 vector_valid", vector_valid, m_valid);
        chk("R4 R5 vector", vector, m_vec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] ack_exp [8] = '{8'h4C, 8'h48, 8'h4A, 8'h4E, 8'h44, 8'h40, 8'h42, 8'h46};
        void'($urandom(32'd1234));
        rst = 1; set_req = 0; clr_req = 0; chan_reset = 0; base_we = 0;
        base_din = 0; iack = 0; reti = 0;
        m_pend = 0; m_ins = 0; m_base = 0; m_vec = 0; m_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R10 irq", irq, 0);
        chk("R10 in_service", in_service, 0);
        chk("R10 vector", vector, 0);
        chk("R10 vector_valid", vector_valid, 0);

        // R1 R2: all pending, acknowledge in priority order
        step(0, 0, 0, 0, 0, 1, 8'h40);
        step(8'hFF, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, 1, 0, 0, 0);
            chk("R1 R2 ack order vector", vector, ack_exp[k]);
        end
        // R6: retire one at a time
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0, 0);
        chk("R6 all retired", in_service, 0);
        // R5: empty acknowledge
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R5 empty ack vector", vector, 8'h40);
        // R7: channel A reset leaves channel B
        step(8'hFF, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'b10, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R7 chan A cleared vector", vector, 8'h44);
        step(0, 0, 2'b01, 0, 1, 0, 0);
        chk("R7 chan B cleared irq", irq, 0);
        // R8: set beats clear on same source
        step(8'h01, 8'h01, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R8 set over clear vector", vector, 8'h40);
        // R9: ack + reti + base write in one cycle
        step(8'h40, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 8'h80);
        chk("R9 old base used", vector, 8'h4C);
        chk("R9 ack still in service", in_service, 1);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R9 both retired", in_service, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R9 new base", vector, 8'h80);

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] s, c;
            for (int b = 0; b < 8; b++) begin
                s[b] = ($urandom % 5) == 0;
                c[b] = ($urandom % 9) == 0;
            end
            step(s, c, 2'(($urandom % 24 == 0) ? ($urandom % 4) : 0),
                 ($urandom % 3) == 0, ($urandom % 3) == 0,
                 ($urandom % 10) == 0, 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule